// File: doc/BRIEF.md
# Byte-Wide Random Byte Register Window

This block puts a random byte source behind a three-register byte window on a simple bus with address, write strobe, read strobe, write data and read data. Software first looks at the hardware status register to learn that a generator is fitted. It then sets the enable bit, polls the data status register until a fresh byte is flagged, and reads the data register to collect that byte. A pseudo-random shift register stands in for a true entropy source.

Each read of a fresh byte uses it up. A refill timer then counts a programmable number of enabled cycles before it loads the next byte. Clearing the enable bit stops the timer and freezes the source. It also withdraws any pending byte, so software never sees stale data after it turns the generator back on. Read data is registered: it changes only on a clock edge at which the read strobe is high.

Top module: `rng_byte_regs`

## Requirements
- R1: After reset the enable bit is 0, the data flag is 0, the read data output is 0x00 and the source state is the seed.
- R2: A read of offset 0 returns 0x40 when enable is 0 and 0x41 when enable is 1. Bit 6 is a fixed present flag, bit 0 is the enable bit and every other bit is 0.
- R3: A write to offset 0 sets the enable bit to bit 0 of the write data and ignores bits 7 to 1.
- R4: Writes to offsets 1, 2 and 3 change neither the enable bit, nor the data flag, nor the pending byte.
- R5: A read of offset 1 returns 0x01 when an unread byte is pending and 0x00 otherwise.
- R6: While enable is 1 and no byte is pending, the flag is set on the REFILL_CYCLES-th rising edge after the edge that consumed the previous byte or wrote enable to 1 (REFILL_CYCLES = 5 in the bench).
- R7: A read of offset 2 while the flag is 1 returns the pending byte and clears the flag on that same edge.
- R8: A read of offset 2 while the flag is 0 returns 0x00 and has no effect on the refill timer.
- R9: The default 16-bit source is seeded with 0xACE1. Each load shifts it right eight times, and after every shift whose outgoing bit was 1 it XORs 0xB400 into the state. The new byte is the low eight bits of the result.
- R10: When enable goes to 0, the flag reads 0 from then on. The source does not advance while enable is 0. After enable is set again, the byte that was pending is skipped and the next byte follows it in the sequence.
- R11: A read of offset 3 returns 0x00.
- R12: Read data changes only on an edge at which the read strobe is 1. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The properties assume that the bus strobes and address are stable around each rising edge and are known values after reset. They also assume that a cycle may carry a read and a write together, which the properties allow for, so the bench never relies on excluding it. The bench drives every input on the falling edge, one access per cycle, and uses only the two-bit offsets 0 to 3. The timing checks are built from that one-access-per-cycle rule: each check counts edges from the write or read that started the refill, and none of them depends on a loop that polls the flag.

// File: rtl/rngr_pkg.sv
package rngr_pkg;

   localparam int OFS_HWSTAT = 0;
   localparam int OFS_DSTAT  = 1;
   localparam int OFS_DATA   = 2;

   localparam logic [7:0] PRESENT_BIT_MASK = 8'h40;
   localparam int         ENABLE_BIT       = 0;

   typedef enum logic [1:0] {
      SEL_HWSTAT,
      SEL_DSTAT,
      SEL_DATA,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/rngr_lfsr.sv
module rngr_lfsr #(
   parameter int           W     = 16,
   parameter logic [W-1:0] SEED  = 'hACE1,
   parameter int           STEPS = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step_i,
   output logic [W-1:0] state_o,
   output logic [7:0]   byte_o
);

   logic [W-1:0] taps;
   logic [W-1:0] state_q;
   logic [W-1:0] nxt;

   // Galois feedback mask picked by width
   if (W == 16) begin : g_w16
      assign taps = W'(16'hB400);
   end else if (W == 32) begin : g_w32
      assign taps = W'(32'h8020_0003);
   end else begin : g_bad_width
      $error("rngr_lfsr: W must be 16 or 32");
      assign taps = '0;
   end

   if (SEED == '0) begin : g_bad_seed
      $error("rngr_lfsr: SEED must be nonzero");
   end

   if (STEPS < 8) begin : g_bad_steps
      $error("rngr_lfsr: STEPS must be at least 8");
   end

   always_comb begin
      nxt = state_q;
      for (int i = 0; i < STEPS; i++) begin
         if (nxt[0]) nxt = (nxt >> 1) ^ taps;
         else        nxt = nxt >> 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= SEED;
      else if (step_i) state_q <= nxt;
   end

   assign state_o = state_q;
   assign byte_o  = state_q[7:0];

endmodule

// File: rtl/rngr_refill.sv
module rngr_refill #(
   parameter int REFILL_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic consume_i,
   output logic load_o,
   output logic valid_o
);

   localparam int CNT_W = (REFILL_CYCLES > 1) ? $clog2(REFILL_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(REFILL_CYCLES - 1);

   if (REFILL_CYCLES < 1) begin : g_bad_refill
      $error("rngr_refill: REFILL_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             valid_q;

   assign load_o  = en_i && !valid_q && (cnt_q == LAST);
   assign valid_o = valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (consume_i) begin
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (load_o) begin
         cnt_q   <= '0;
         valid_q <= 1'b1;
      end else if (!valid_q) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/rngr_regs.sv
module rngr_regs
   import rngr_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [7:0]        wdata_i,
   input  logic              valid_i,
   input  logic [7:0]        byte_i,
   output logic              en_o,
   output logic              consume_o,
   output logic [7:0]        rdata_o
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("rngr_regs: ADDR_W must be at least 2");
   end

   reg_sel_e   sel;
   logic       en_q;
   logic       flag;
   logic [7:0] rd_val;
   logic [7:0] rdata_q;
   logic       unused_wdata;

   assign unused_wdata = ^wdata_i[7:1];

   always_comb begin
      if (addr_i == ADDR_W'(OFS_HWSTAT))     sel = SEL_HWSTAT;
      else if (addr_i == ADDR_W'(OFS_DSTAT)) sel = SEL_DSTAT;
      else if (addr_i == ADDR_W'(OFS_DATA))  sel = SEL_DATA;
      else                                   sel = SEL_NONE;
   end

   assign flag      = valid_i && en_q;
   assign consume_o = rd_i && (sel == SEL_DATA) && flag;

   always_comb begin
      unique case (sel)
         SEL_HWSTAT: rd_val = PRESENT_BIT_MASK | {7'b0, en_q};
         SEL_DSTAT:  rd_val = {7'b0, flag};
         SEL_DATA:   rd_val = flag ? byte_i : 8'h00;
         default:    rd_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         rdata_q <= 8'h00;
      end else begin
         if (wr_i && (sel == SEL_HWSTAT)) en_q <= wdata_i[ENABLE_BIT];
         if (rd_i)                        rdata_q <= rd_val;
      end
   end

   assign en_o    = en_q;
   assign rdata_o = rdata_q;

endmodule

// File: rtl/rng_byte_regs.sv
module rng_byte_regs #(
   parameter int ADDR_W        = 2,
   parameter int LFSR_W        = 16,
   parameter int LFSR_SEED     = 'hACE1,
   parameter int REFILL_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);

   logic              en_w;
   logic              consume_w;
   logic              load_w;
   logic              valid_w;
   logic [7:0]        byte_w;
   logic [LFSR_W-1:0] lfsr_state_w;

   rngr_regs #(
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (bus_addr),
      .wr_i      (bus_wr),
      .rd_i      (bus_rd),
      .wdata_i   (bus_wdata),
      .valid_i   (valid_w),
      .byte_i    (byte_w),
      .en_o      (en_w),
      .consume_o (consume_w),
      .rdata_o   (bus_rdata)
   );

   rngr_refill #(
      .REFILL_CYCLES (REFILL_CYCLES)
   ) u_refill (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_w),
      .consume_i (consume_w),
      .load_o    (load_w),
      .valid_o   (valid_w)
   );

   rngr_lfsr #(
      .W     (LFSR_W),
      .SEED  (LFSR_W'(LFSR_SEED)),
      .STEPS (8)
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (load_w),
      .state_o (lfsr_state_w),
      .byte_o  (byte_w)
   );

endmodule

// File: rtl/rngr_checker.sv
module rngr_checker #(
   parameter int ADDR_W = 2,
   parameter int LFSR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              en_q,
   input logic              valid_q,
   input logic              load,
   input logic [LFSR_W-1:0] lfsr_state
);

   p_hw_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == ADDR_W'(0) |=>
         bus_rdata[7:1] == 7'b0100000 && bus_rdata[0] == $past(en_q));

   p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(0) |=> en_q == $past(bus_wdata[0]));

   p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == ADDR_W'(0)) |=> $stable(en_q));

   p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_q) |-> $past(en_q));

   p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == ADDR_W'(2) && valid_q && en_q |=> !valid_q);

   p_src_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);

   p_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !valid_q);

   p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(lfsr_state));

   p_beyond_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr > ADDR_W'(2) |=> bus_rdata == 8'h00);

   p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

endmodule

bind rng_byte_regs rngr_checker #(
   .ADDR_W (ADDR_W),
   .LFSR_W (LFSR_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .en_q       (en_w),
   .valid_q    (valid_w),
   .load       (load_w),
   .lfsr_state (lfsr_state_w)
);

// File: tb/test_rng_byte_regs.sv
`timescale 1ns/1ps
module test_rng_byte_regs;

   localparam int REF = 5;

   typedef struct packed {
      logic       is_wr;
      logic [1:0] addr;
      logic [7:0] wdata;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   // Register-decode vectors, applied from reset with enable 0
   localparam vec_t VEC [0:11] = '{
      '{1'b0, 2'd0, 8'h00, 8'h40, 4'd2},   // R2 status, disabled
      '{1'b0, 2'd1, 8'h00, 8'h00, 4'd5},   // R5 no byte pending
      '{1'b0, 2'd2, 8'h00, 8'h00, 4'd8},   // R8 data read without flag
      '{1'b0, 2'd3, 8'h00, 8'h00, 4'd11},  // R11 beyond window
      '{1'b1, 2'd0, 8'hFE, 8'h00, 4'd3},   // R3 upper bits only
      '{1'b0, 2'd0, 8'h00, 8'h40, 4'd3},   // R3 enable still 0
      '{1'b1, 2'd1, 8'hFF, 8'h00, 4'd4},   // R4 write offset 1
      '{1'b1, 2'd2, 8'hFF, 8'h00, 4'd4},   // R4 write offset 2
      '{1'b1, 2'd3, 8'hFF, 8'h00, 4'd4},   // R4 write offset 3
      '{1'b0, 2'd0, 8'h00, 8'h40, 4'd4},   // R4 enable untouched
      '{1'b1, 2'd0, 8'h01, 8'h00, 4'd3},   // R3 set enable
      '{1'b0, 2'd0, 8'h00, 8'h41, 4'd2}    // R2 status, enabled
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;

   int          n_chk = 0;
   int          n_bad = 0;
   logic [15:0] mdl;

   always #5 clk = ~clk;

   rng_byte_regs #(
      .REFILL_CYCLES (REF)
   ) i_rng_byte_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (addr),
      .bus_wr    (wr),
      .bus_rd    (rd),
      .bus_wdata (wdata),
      .bus_rdata (rdata)
   );

   function automatic logic [15:0] step8(input logic [15:0] s);
      logic [15:0] t;
      t = s;
      for (int i = 0; i < 8; i++) begin
         if (t[0]) t = (t >> 1) ^ 16'hB400;
         else      t = t >> 1;
      end
      return t;
   endfunction

   task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      rd   = 1'b1;
      @(negedge clk);
      d  = rdata;
      rd = 1'b0;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      addr  = a;
      wdata = d;
      wr    = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      rd    = 1'b0;
      wr    = 1'b0;
      addr  = '0;
      wdata = '0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   // Flag low on the REF-th edge's read, high on the next one
   task automatic expect_refill(input string tag);
      logic [7:0] d;
      idle(REF - 1);
      bus_read(2'd1, d);
      check(d, 8'h00, {tag, " flag still low"});
      bus_read(2'd1, d);
      check(d, 8'h01, {tag, " flag set"});
   endtask

   task automatic poll_flag(input string tag);
      logic [7:0] d;
      d = 8'h00;
      for (int i = 0; i < 4 * REF && d != 8'h01; i++) bus_read(2'd1, d);
      check(d, 8'h01, tag);
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      logic [7:0] d;

      // R1 reset state
      apply_reset();
      check(rdata, 8'h00, "R1 rdata after reset");
      bus_read(2'd0, d);
      check(d, 8'h40, "R1 enable clear");
      bus_read(2'd1, d);
      check(d, 8'h00, "R1 flag clear");

      // Table walk
      for (int v = 0; v < 12; v++) begin
         if (VEC[v].is_wr) begin
            bus_write(VEC[v].addr, VEC[v].wdata);
         end else begin
            bus_read(VEC[v].addr, d);
            check(d, VEC[v].exp, $sformatf("R%0d vector %0d", VEC[v].req, v));
         end
      end

      // R6 R7 R9 exact refill timing and byte sequence
      apply_reset();
      mdl = 16'hACE1;
      bus_write(2'd0, 8'h01);
      expect_refill("R6 after enable");
      bus_read(2'd2, d);
      mdl = step8(mdl);
      check(d, mdl[7:0], "R7 R9 first byte");
      expect_refill("R6 R7 after consume");
      bus_read(2'd2, d);
      mdl = step8(mdl);
      check(d, mdl[7:0], "R9 second byte");

      // R12 hold without read strobe
      idle(4);
      check(rdata, mdl[7:0], "R12 rdata held");

      // R8 read without a pending byte
      bus_read(2'd2, d);
      check(d, 8'h00, "R8 empty data read");

      // R4 writes to offsets 1 and 2 leave a pending byte alone
      poll_flag("R6 third byte flag");
      bus_write(2'd1, 8'h00);
      bus_write(2'd2, 8'h00);
      bus_read(2'd1, d);
      check(d, 8'h01, "R4 flag kept");
      bus_read(2'd2, d);
      mdl = step8(mdl);
      check(d, mdl[7:0], "R4 R9 third byte kept");

      // R10 disable with a byte pending
      poll_flag("R6 fourth byte flag");
      mdl = step8(mdl);
      bus_write(2'd0, 8'h00);
      bus_read(2'd1, d);
      check(d, 8'h00, "R10 flag drops on disable");
      idle(3 * REF);
      bus_read(2'd1, d);
      check(d, 8'h00, "R10 flag stays low");
      bus_read(2'd2, d);
      check(d, 8'h00, "R10 R8 data while disabled");
      bus_write(2'd0, 8'h01);
      expect_refill("R10 resume");
      bus_read(2'd2, d);
      mdl = step8(mdl);
      check(d, mdl[7:0], "R10 R9 sequence resumes");

      // R11 beyond window while enabled
      bus_read(2'd3, d);
      check(d, 8'h00, "R11 offset 3 enabled");

      report();
      $finish;
   end

endmodule